// File: doc/BRIEF.md
# UART Register Front End

This block is the software-visible register bank of a UART. A simple 32-bit register bus (byte address, write strobe, write data, read strobe, registered read data) reaches ten word registers through it. Those registers hold the character format, the modem control lines, the baud divisor and the interrupt enables. They also give access to the transmit and receive FIFOs that sit outside the block. The serializer, deserializer, FIFO storage and baud generator are neighbours. This block only issues push, pop and flush strobes to the FIFOs and observes their full, empty and occupancy signals.

Received-character error flags come from the head of the receive FIFO and are presented in the line status word. A lost-character indication from the deserializer is held until software reads line status. A single level interrupt merges receive-data-available and transmit-space-available, each gated by its own enable bit. The enable bits and the pending bits share one register.

Word offsets, selected by address bits above bit 1: 0x00 data, 0x04 line status, 0x08 modem status, 0x0C line control, 0x10 modem control, 0x14 divisor low, 0x18 divisor high, 0x1C interrupt control/status, 0x20 TX occupancy, 0x24 RX occupancy. Unmapped offsets read as zero. Read data appears on `bus_rdata` at the clock edge that samples `bus_rd` and holds until the next read.

Top module: `uart_reg_front`

## Requirements
- R1: After synchronous reset, line control reads 0x03 (8-bit words, `word_len`=3) and modem control, divisor low/high and both interrupt enables read zero; `irq` is low while the enables are zero.
- R2: A write to offset 0x00 asserts `txf_push` in the same cycle with `txf_data` = `bus_wdata[7:0]` when `txf_full` is low; when `txf_full` is high the write is dropped and `txf_push` stays low.
- R3: A read of offset 0x00 with `rxf_empty` low asserts `rxf_pop` in that cycle and returns `rxf_data` zero-extended; with `rxf_empty` high it returns 0 and `rxf_pop` stays low.
- R4: Line status (0x04) bit 6 = `txf_empty` AND `tx_idle`, bit 1 = NOT `rxf_empty`, bit 0 = NOT `txf_full`; bits 31:7 read zero.
- R5: Line status bit 5 = `rxf_brk`, bit 4 = `rxf_ferr`, bit 2 = `rxf_perr`, each describing the head character and forced to 0 while `rxf_empty` is high.
- R6: Line status bit 3 is set by a `rx_overrun` pulse and stays set until line status is read; that read returns 1 and clears it, except that a pulse in the same cycle as the read leaves it set (the read then returns the prior value).
- R7: Line control (0x0C) bits [1:0] drive `word_len`, bit 2 `two_stop`, bit 3 `par_en`, bit 4 `par_even` (1 = even) and bit 5 `brk_force`; it reads back the six stored bits with the rest zero.
- R8: Modem control (0x10) bit 4 drives `loopback`, bit 3 `ri_out`, bit 2 `dcd_out`, bit 1 `rts_out` and bit 0 `dtr_out` and reads back; modem status (0x08) returns `modem_sts` in bits [3:0].
- R9: Divisor low (0x14) stores bits [7:0] as `baud_div[7:0]` and bits [15:12] as `baud_ext`; divisor high (0x18) stores bits [7:0] as `baud_div[15:8]`; both read back the stored fields in the same positions.
- R10: Interrupt register (0x1C) bit 5 is the RX enable and bit 4 the TX enable (writable); bit 1 reads NOT `rxf_empty` and bit 0 NOT `txf_full`; writes to bits 1:0 have no effect.
- R11: `irq` = (RX enable AND NOT `rxf_empty`) OR (TX enable AND NOT `txf_full`), following its inputs in the same cycle.
- R12: Any write to 0x24 asserts `rxf_flush` for exactly that cycle; a write to 0x20 asserts neither flush nor push; reads of 0x20 and 0x24 return `txf_count` and `rxf_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| txf_push | output | 1 | Push into TX FIFO |
| txf_data | output | DATA_W | Character pushed |
| txf_full | input | 1 | TX FIFO full |
| txf_empty | input | 1 | TX FIFO empty |
| txf_count | input | CNT_W | TX FIFO occupancy |
| tx_idle | input | 1 | Serializer has no character in flight |
| rxf_pop | output | 1 | Pop from RX FIFO |
| rxf_flush | output | 1 | Discard RX FIFO contents |
| rxf_data | input | DATA_W | Head character of RX FIFO |
| rxf_empty | input | 1 | RX FIFO empty |
| rxf_count | input | CNT_W | RX FIFO occupancy |
| rxf_perr | input | 1 | Head character parity error |
| rxf_ferr | input | 1 | Head character framing error |
| rxf_brk | input | 1 | Head character is a break |
| rx_overrun | input | 1 | One-cycle pulse: a received character was lost |
| modem_sts | input | 4 | Modem input lines |
| word_len | output | 2 | Character length code (0..3 = 5..8 bits) |
| two_stop | output | 1 | Two stop bits |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| brk_force | output | 1 | Hold the line in break |
| loopback | output | 1 | Internal loopback |
| ri_out | output | 1 | Ring indicator output |
| dcd_out | output | 1 | Carrier detect output |
| rts_out | output | 1 | Request to send |
| dtr_out | output | 1 | Data terminal ready |
| baud_div | output | 16 | Integer baud divisor |
| baud_ext | output | 4 | Fractional divisor extension |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the strobe edges. It writes data while the TX FIFO reports full, which a faulty design would turn into a push that corrupts the FIFO. It reads data while the RX FIFO is empty, which a faulty design would turn into a pop or a stale byte. For the overrun flag it checks clear-on-read, and it checks a pulse that lands in the same cycle as the status read. A design that let the clear win would lose that overrun silently. It checks that head-character error flags are masked when the RX FIFO is empty, since unmasked flags would report a phantom error. It checks that the interrupt follows each enable separately, that a TX-residue write never flushes and that divisor fields land in their split positions. A design that swapped the enables would fire for the wrong cause, and misplaced divisor fields would program a wrong baud rate.

// File: rtl/uart_reg_front_pkg.sv
package uart_reg_front_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [3:0] {
        SEL_DATA  = 4'd0,
        SEL_LSR   = 4'd1,
        SEL_MSR   = 4'd2,
        SEL_LCR   = 4'd3,
        SEL_MCR   = 4'd4,
        SEL_DIVL  = 4'd5,
        SEL_DIVH  = 4'd6,
        SEL_ISC   = 4'd7,
        SEL_TXRES = 4'd8,
        SEL_RXRES = 4'd9,
        SEL_NONE  = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic       brk;
        logic       par_even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } line_ctl_t;

    typedef struct packed {
        logic loop;
        logic ri;
        logic dcd;
        logic rts;
        logic dtr;
    } modem_ctl_t;

    localparam line_ctl_t LCR_RESET = '{brk: 1'b0, par_even: 1'b0, par_en: 1'b0,
                                        two_stop: 1'b0, wlen: 2'd3};

    function automatic reg_sel_e decode_sel(input logic [7:0] widx);
        case (widx)
            8'd0: return SEL_DATA;
            8'd1: return SEL_LSR;
            8'd2: return SEL_MSR;
            8'd3: return SEL_LCR;
            8'd4: return SEL_MCR;
            8'd5: return SEL_DIVL;
            8'd6: return SEL_DIVH;
            8'd7: return SEL_ISC;
            8'd8: return SEL_TXRES;
            8'd9: return SEL_RXRES;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uart_reg_front_ctrl.sv
module uart_reg_front_ctrl
    import uart_reg_front_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [15:0] wdata,
    output line_ctl_t   lcr,
    output modem_ctl_t  mcr,
    output logic [7:0]  div_lo,
    output logic [3:0]  div_ext,
    output logic [7:0]  div_hi,
    output logic        rx_ie,
    output logic        tx_ie
);

    logic unused_mid;
    assign unused_mid = ^wdata[11:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr     <= LCR_RESET;
            mcr     <= '0;
            div_lo  <= '0;
            div_ext <= '0;
            div_hi  <= '0;
            rx_ie   <= 1'b0;
            tx_ie   <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_LCR:  lcr <= line_ctl_t'(wdata[5:0]);
                SEL_MCR:  mcr <= modem_ctl_t'(wdata[4:0]);
                SEL_DIVL: begin
                    div_lo  <= wdata[7:0];
                    div_ext <= wdata[15:12];
                end
                SEL_DIVH: div_hi <= wdata[7:0];
                SEL_ISC:  begin
                    rx_ie <= wdata[5];
                    tx_ie <= wdata[4];
                end
                default: ;
            endcase
        end
    end

    assert_wlen_default_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lcr.wlen == 2'd3 && !rx_ie && !tx_ie));

    assert_lcr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_LCR) |=> $stable(lcr));

endmodule

// File: rtl/uart_reg_front_status.sv
module uart_reg_front_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_overrun,
    input  logic       lsr_read,
    input  logic       rx_empty,
    input  logic       tx_full,
    input  logic       tx_empty,
    input  logic       tx_idle,
    input  logic       head_perr,
    input  logic       head_ferr,
    input  logic       head_brk,
    input  logic       rx_ie,
    input  logic       tx_ie,
    output logic [6:0] lsr,
    output logic       rx_pend,
    output logic       tx_pend,
    output logic       irq
);

    logic ovr_q;

    always_ff @(posedge clk) begin
        if (rst)             ovr_q <= 1'b0;
        else if (rx_overrun) ovr_q <= 1'b1;
        else if (lsr_read)   ovr_q <= 1'b0;
    end

    assign rx_pend = !rx_empty;
    assign tx_pend = !tx_full;

    always_comb begin
        lsr    = '0;
        lsr[6] = tx_empty & tx_idle;
        lsr[5] = rx_pend & head_brk;
        lsr[4] = rx_pend & head_ferr;
        lsr[3] = ovr_q;
        lsr[2] = rx_pend & head_perr;
        lsr[1] = rx_pend;
        lsr[0] = tx_pend;
    end

    assign irq = (rx_ie & rx_pend) | (tx_ie & tx_pend);

    assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> ovr_q);

    assert_head_mask_R5: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> (lsr[5:4] == 2'b00 && !lsr[2]));

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!rx_ie && !tx_ie) |-> !irq);

endmodule

// File: rtl/uart_reg_front_port.sv
module uart_reg_front_port
    import uart_reg_front_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] wchar,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              txf_push,
    output logic [DATA_W-1:0] txf_data,
    input  logic              txf_full,
    output logic              rxf_pop,
    output logic              rxf_flush,
    input  logic              rxf_empty,
    input  logic [DATA_W-1:0] rxf_data,
    input  logic [CNT_W-1:0]  txf_count,
    input  logic [CNT_W-1:0]  rxf_count,
    input  logic [6:0]        lsr,
    input  logic [3:0]        msr,
    input  logic [5:0]        lcr_bits,
    input  logic [4:0]        mcr_bits,
    input  logic [15:0]       divl_bits,
    input  logic [7:0]        divh_bits,
    input  logic [5:0]        isc_bits
);

    logic [BUS_W-1:0] rd_value;

    assign txf_push  = bus_wr && sel == SEL_DATA && !txf_full;
    assign txf_data  = wchar;
    assign rxf_flush = bus_wr && sel == SEL_RXRES;
    assign rxf_pop   = bus_rd && sel == SEL_DATA && !rxf_empty;

    always_comb begin
        rd_value = '0;
        case (sel)
            SEL_DATA:  rd_value = rxf_empty ? '0 : BUS_W'(rxf_data);
            SEL_LSR:   rd_value = BUS_W'(lsr);
            SEL_MSR:   rd_value = BUS_W'(msr);
            SEL_LCR:   rd_value = BUS_W'(lcr_bits);
            SEL_MCR:   rd_value = BUS_W'(mcr_bits);
            SEL_DIVL:  rd_value = BUS_W'(divl_bits);
            SEL_DIVH:  rd_value = BUS_W'(divh_bits);
            SEL_ISC:   rd_value = BUS_W'(isc_bits);
            SEL_TXRES: rd_value = BUS_W'(txf_count);
            SEL_RXRES: rd_value = BUS_W'(rxf_count);
            default:   rd_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_value;
    end

    assert_no_push_full_R2: assert property (@(posedge clk) disable iff (rst)
        txf_full |-> !txf_push);

    assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (rst)
        rxf_empty |-> !rxf_pop);

    assert_flush_needs_write_R12: assert property (@(posedge clk) disable iff (rst)
        rxf_flush |-> (bus_wr && !txf_push));

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
    import uart_reg_front_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 128,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              txf_push,
    output logic [DATA_W-1:0] txf_data,
    input  logic              txf_full,
    input  logic              txf_empty,
    input  logic [CNT_W-1:0]  txf_count,
    input  logic              tx_idle,
    output logic              rxf_pop,
    output logic              rxf_flush,
    input  logic [DATA_W-1:0] rxf_data,
    input  logic              rxf_empty,
    input  logic [CNT_W-1:0]  rxf_count,
    input  logic              rxf_perr,
    input  logic              rxf_ferr,
    input  logic              rxf_brk,
    input  logic              rx_overrun,
    input  logic [3:0]        modem_sts,
    output logic [1:0]        word_len,
    output logic              two_stop,
    output logic              par_en,
    output logic              par_even,
    output logic              brk_force,
    output logic              loopback,
    output logic              ri_out,
    output logic              dcd_out,
    output logic              rts_out,
    output logic              dtr_out,
    output logic [15:0]       baud_div,
    output logic [3:0]        baud_ext,
    output logic              irq
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    reg_sel_e          sel;
    line_ctl_t         lcr;
    modem_ctl_t        mcr;
    logic [7:0]        div_lo, div_hi;
    logic [3:0]        div_ext;
    logic              rx_ie, tx_ie, rx_pend, tx_pend;
    logic [6:0]        lsr;
    logic              unused_bus;

    assign unused_bus = ^{bus_addr[1:0], bus_wdata[31:16]};
    assign widx       = bus_addr[ADDR_W-1:2];
    assign sel        = decode_sel(8'(widx));

    uart_reg_front_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .sel(sel), .wdata(bus_wdata[15:0]),
        .lcr(lcr), .mcr(mcr), .div_lo(div_lo), .div_ext(div_ext), .div_hi(div_hi),
        .rx_ie(rx_ie), .tx_ie(tx_ie)
    );

    uart_reg_front_status u_status (
        .clk(clk), .rst(rst), .rx_overrun(rx_overrun),
        .lsr_read(bus_rd && sel == SEL_LSR),
        .rx_empty(rxf_empty), .tx_full(txf_full), .tx_empty(txf_empty), .tx_idle(tx_idle),
        .head_perr(rxf_perr), .head_ferr(rxf_ferr), .head_brk(rxf_brk),
        .rx_ie(rx_ie), .tx_ie(tx_ie),
        .lsr(lsr), .rx_pend(rx_pend), .tx_pend(tx_pend), .irq(irq)
    );

    uart_reg_front_port #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_port (
        .clk(clk), .rst(rst), .sel(sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .wchar(bus_wdata[DATA_W-1:0]), .bus_rdata(bus_rdata),
        .txf_push(txf_push), .txf_data(txf_data), .txf_full(txf_full),
        .rxf_pop(rxf_pop), .rxf_flush(rxf_flush), .rxf_empty(rxf_empty), .rxf_data(rxf_data),
        .txf_count(txf_count), .rxf_count(rxf_count),
        .lsr(lsr), .msr(modem_sts), .lcr_bits(lcr), .mcr_bits(mcr),
        .divl_bits({div_ext, 4'b0000, div_lo}), .divh_bits(div_hi),
        .isc_bits({rx_ie, tx_ie, 2'b00, rx_pend, tx_pend})
    );

    assign word_len  = lcr.wlen;
    assign two_stop  = lcr.two_stop;
    assign par_en    = lcr.par_en;
    assign par_even  = lcr.par_even;
    assign brk_force = lcr.brk;
    assign loopback  = mcr.loop;
    assign ri_out    = mcr.ri;
    assign dcd_out   = mcr.dcd;
    assign rts_out   = mcr.rts;
    assign dtr_out   = mcr.dtr;
    assign baud_div  = {div_hi, div_lo};
    assign baud_ext  = div_ext;

endmodule

// File: tb/uart_reg_front_test.sv
module uart_reg_front_test;

    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txf_push, rxf_pop, rxf_flush;
    logic [7:0]  txf_data;
    logic        txf_full = 1'b0, txf_empty = 1'b1, tx_idle = 1'b1;
    logic [CNT_W-1:0] txf_count = '0, rxf_count = '0;
    logic [7:0]  rxf_data = '0;
    logic        rxf_empty = 1'b1, rxf_perr = 1'b0, rxf_ferr = 1'b0, rxf_brk = 1'b0;
    logic        rx_overrun = 1'b0;
    logic [3:0]  modem_sts = '0;
    logic [1:0]  word_len;
    logic        two_stop, par_en, par_even, brk_force;
    logic        loopback, ri_out, dcd_out, rts_out, dtr_out;
    logic [15:0] baud_div;
    logic [3:0]  baud_ext;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    uart_reg_front uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .txf_push(txf_push), .txf_data(txf_data),
        .txf_full(txf_full), .txf_empty(txf_empty), .txf_count(txf_count), .tx_idle(tx_idle),
        .rxf_pop(rxf_pop), .rxf_flush(rxf_flush), .rxf_data(rxf_data), .rxf_empty(rxf_empty),
        .rxf_count(rxf_count), .rxf_perr(rxf_perr), .rxf_ferr(rxf_ferr), .rxf_brk(rxf_brk),
        .rx_overrun(rx_overrun), .modem_sts(modem_sts), .word_len(word_len),
        .two_stop(two_stop), .par_en(par_en), .par_even(par_even), .brk_force(brk_force),
        .loopback(loopback), .ri_out(ri_out), .dcd_out(dcd_out), .rts_out(rts_out),
        .dtr_out(dtr_out), .baud_div(baud_div), .baud_ext(baud_ext), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Driver: a read pushes the expected word; the monitor compares it.
    task automatic do_read(input logic [5:0] a, input logic [31:0] exp, input logic exp_pop,
                           input logic ovr_pulse, input string tag);
        @(negedge clk);
        bus_addr   = a;
        bus_rd     = 1'b1;
        rx_overrun = ovr_pulse;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #1;
        check({tag, " pop"}, {31'b0, rxf_pop}, {31'b0, exp_pop});
        @(negedge clk);
        bus_rd     = 1'b0;
        rx_overrun = 1'b0;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d, input logic exp_push,
                            input logic exp_flush, input string tag);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        #1;
        check({tag, " push"}, {31'b0, txf_push}, {31'b0, exp_push});
        check({tag, " flush"}, {31'b0, rxf_flush}, {31'b0, exp_flush});
        if (exp_push) check({tag, " txdata"}, {24'b0, txf_data}, {24'b0, d[7:0]});
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        if (exp_flush) check({tag, " flush one cycle"}, {31'b0, rxf_flush}, 32'd0);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                #1;
                if (exp_q.size() == 0) check("monitor queue", 32'd1, 32'd0);
                else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 word_len", {30'b0, word_len}, 32'd3);
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 strobes", {29'b0, txf_push, rxf_pop, rxf_flush}, 32'd0);
        do_read(6'h0C, 32'h03, 1'b0, 1'b0, "R1 lcr");
        do_read(6'h10, 32'h00, 1'b0, 1'b0, "R1 mcr");
        do_read(6'h14, 32'h00, 1'b0, 1'b0, "R1 divl");
        do_read(6'h18, 32'h00, 1'b0, 1'b0, "R1 divh");
        do_read(6'h1C, 32'h01, 1'b0, 1'b0, "R1 isc");
        do_read(6'h3C, 32'h00, 1'b0, 1'b0, "R1 unmapped");

        // R2 transmit push / drop when full
        do_write(6'h00, 32'h0000_01A5, 1'b1, 1'b0, "R2 push");
        txf_full = 1'b1;
        do_write(6'h00, 32'h0000_0033, 1'b0, 1'b0, "R2 full drop");

        // R3 receive pop / empty read
        rxf_empty = 1'b0; rxf_data = 8'h5C;
        do_read(6'h00, 32'h5C, 1'b1, 1'b0, "R3 pop");
        rxf_empty = 1'b1;
        do_read(6'h00, 32'h00, 1'b0, 1'b0, "R3 empty");

        // R4 line status basic bits
        txf_full = 1'b0; txf_empty = 1'b1; tx_idle = 1'b1;
        do_read(6'h04, 32'h41, 1'b0, 1'b0, "R4 idle");
        tx_idle = 1'b0;
        do_read(6'h04, 32'h01, 1'b0, 1'b0, "R4 shifting");
        txf_full = 1'b1; txf_empty = 1'b0; rxf_empty = 1'b0;
        do_read(6'h04, 32'h02, 1'b0, 1'b0, "R4 rx avail");

        // R5 head character flags
        rxf_perr = 1'b1; rxf_ferr = 1'b1; rxf_brk = 1'b1;
        do_read(6'h04, 32'h36, 1'b0, 1'b0, "R5 flags");
        rxf_empty = 1'b1;
        do_read(6'h04, 32'h00, 1'b0, 1'b0, "R5 masked");
        rxf_perr = 1'b0; rxf_ferr = 1'b0; rxf_brk = 1'b0;

        // R6 sticky overrun
        @(negedge clk); rx_overrun = 1'b1;
        @(negedge clk); rx_overrun = 1'b0;
        do_read(6'h04, 32'h08, 1'b0, 1'b0, "R6 set");
        do_read(6'h04, 32'h00, 1'b0, 1'b0, "R6 cleared");
        do_read(6'h04, 32'h00, 1'b0, 1'b1, "R6 pulse with read");
        do_read(6'h04, 32'h08, 1'b0, 1'b0, "R6 kept");
        do_read(6'h04, 32'h00, 1'b0, 1'b0, "R6 cleared again");

        // R7 line control
        do_write(6'h0C, 32'h0000_003E, 1'b0, 1'b0, "R7 wr");
        check("R7 fields", {25'b0, brk_force, par_even, par_en, two_stop, word_len}, 32'h3E);
        do_read(6'h0C, 32'h3E, 1'b0, 1'b0, "R7 rd");
        do_write(6'h0C, 32'hFFFF_FFC1, 1'b0, 1'b0, "R7 wr2");
        check("R7 fields2", {25'b0, brk_force, par_even, par_en, two_stop, word_len}, 32'h01);
        do_read(6'h0C, 32'h01, 1'b0, 1'b0, "R7 rd2");

        // R8 modem control / status
        do_write(6'h10, 32'h0000_0015, 1'b0, 1'b0, "R8 wr");
        check("R8 fields", {27'b0, loopback, ri_out, dcd_out, rts_out, dtr_out}, 32'h15);
        do_read(6'h10, 32'h15, 1'b0, 1'b0, "R8 rd");
        modem_sts = 4'hA;
        do_read(6'h08, 32'h0A, 1'b0, 1'b0, "R8 msr");

        // R9 divisor
        do_write(6'h14, 32'h0000_B07F, 1'b0, 1'b0, "R9 divl");
        do_write(6'h18, 32'h0000_0012, 1'b0, 1'b0, "R9 divh");
        check("R9 div", {16'b0, baud_div}, 32'h127F);
        check("R9 ext", {28'b0, baud_ext}, 32'hB);
        do_read(6'h14, 32'hB07F, 1'b0, 1'b0, "R9 divl rd");
        do_read(6'h18, 32'h12, 1'b0, 1'b0, "R9 divh rd");

        // R10 / R11 interrupt control
        rxf_empty = 1'b1; txf_full = 1'b1;
        do_write(6'h1C, 32'h0000_0033, 1'b0, 1'b0, "R10 wr");
        do_read(6'h1C, 32'h30, 1'b0, 1'b0, "R10 no pending");
        check("R11 none pending", {31'b0, irq}, 32'd0);
        rxf_empty = 1'b0; #1;
        check("R11 rx irq", {31'b0, irq}, 32'd1);
        do_read(6'h1C, 32'h32, 1'b0, 1'b0, "R10 rx pending");
        rxf_empty = 1'b1; txf_full = 1'b0; #1;
        check("R11 tx irq", {31'b0, irq}, 32'd1);
        do_write(6'h1C, 32'h0000_0010, 1'b0, 1'b0, "R10 tx only");
        rxf_empty = 1'b0; txf_full = 1'b1; #1;
        check("R11 rx disabled", {31'b0, irq}, 32'd0);
        do_write(6'h1C, 32'h0000_0000, 1'b0, 1'b0, "R10 off");
        txf_full = 1'b0; #1;
        check("R11 all disabled", {31'b0, irq}, 32'd0);

        // R12 residue registers
        rxf_empty = 1'b1; txf_full = 1'b0;
        do_write(6'h24, 32'h0000_0000, 1'b0, 1'b1, "R12 rx flush");
        do_write(6'h20, 32'h0000_00FF, 1'b0, 1'b0, "R12 tx residue wr");
        txf_count = 8'h80; rxf_count = 8'h05;
        do_read(6'h20, 32'h80, 1'b0, 1'b0, "R12 tx count");
        do_read(6'h24, 32'h05, 1'b0, 1'b0, "R12 rx count");

        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule